// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block holds the breakpoint settings of a processor's debug logic and compares them every cycle with the core's operand address, address attribute and program counter. Its settings live in a small file of 32-bit registers. Each register is selected by a 5-bit register number. Two masters can write the file. The first is the external debug command path, which can also read registers back. The second is the processor's supervisor debug-write path. A lock bit in the control register is writable only by the external host. While the lock is set, processor writes to the breakpoint registers are ignored.

An operand address match needs two things. The address must lie within an inclusive lower/upper window. The core's attribute bits must equal a programmed value in every bit position the mask does not exclude. Each program-counter breakpoint register raises its own hit line, but only when its valid bit is set. Every command on the external path gets a response one cycle later. A write returns the completion word 0x0000FFFF, and a read returns the register's contents.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset every register holds zero, so every read returns 0x00000000, `pc_hit_o` is all zero and `resp_vld_o` is low.
- R2: One cycle after `ext_wr_i` is high, `resp_vld_o` is high and `resp_o` is 0x0000FFFF. When no command is given, `resp_vld_o` is low in the next cycle.
- R3: One cycle after `ext_rd_i` is high, `resp_vld_o` is high and `resp_o` holds the selected register. Unimplemented bits read as zero. The register numbers are: 0x00 control, with the lock in bit 0; 0x08 lower bound; 0x09 upper bound; 0x0A attribute, with the value in bits [7:0] and the mask in bits [23:16]; 0x0B PC-valid bits, with bit k for PC register k; 0x10+k PC breakpoint k, for k = 0..3.
- R4: A read of any register number not listed in R3 returns zero.
- R5: While the lock is clear, a processor write (`cpu_wr_i`) updates the selected breakpoint register (0x08 to 0x0B, 0x10 to 0x13).
- R6: While the lock is set, processor writes leave every breakpoint register unchanged. Processor writes to the control register are ignored at all times.
- R7: If both masters write the same register in the same cycle, the external write data is stored.
- R8: `in_range_o` is high exactly when lower <= `core_addr_i` <= upper, with the compare unsigned and inclusive of both bounds.
- R9: `attr_ok_o` is high when each bit of `core_attr_i` equals the programmed value wherever the mask bit is 0. A mask bit of 1 ignores that bit. `addr_hit_o` is `in_range_o` AND `attr_ok_o`.
- R10: `pc_hit_o[k]` is high exactly when valid bit k is set and `core_pc_i` equals PC breakpoint register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_wr_i | input | 1 | External host register write command |
| ext_rd_i | input | 1 | External host register read command |
| ext_num_i | input | 5 | Register number for the external command |
| ext_wdata_i | input | 32 | External write data |
| resp_vld_o | output | 1 | Response valid, one cycle after a command |
| resp_o | output | 32 | Completion word or read data |
| cpu_wr_i | input | 1 | Processor supervisor debug write |
| cpu_num_i | input | 5 | Register number for the processor write |
| cpu_wdata_i | input | 32 | Processor write data |
| core_addr_i | input | 32 | Core operand logical address |
| core_attr_i | input | 8 | Core address attribute bits |
| core_pc_i | input | 32 | Core program counter |
| in_range_o | output | 1 | Address lies within the bounds |
| attr_ok_o | output | 1 | Masked attribute compare matches |
| addr_hit_o | output | 1 | Range and attribute both match |
| pc_hit_o | output | 4 | Per-register PC breakpoint hit |

## Verification
The bench probes the addresses at both bounds and the addresses one step outside them. An off-by-one or exclusive compare would miss a bound or fire just past it. It makes processor writes while the lock is set, and also tries to clear the lock from the processor side. A missing lock gate would let the processor overwrite the settings. It issues a write from both masters to the same register in the same cycle. The wrong priority would store the processor's data. It also programs a PC value into a register whose valid bit is clear and reads an attribute register written all-ones. A missing valid qualifier would raise a false hit, and bits that are not masked off would read back as ones.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_W  = 5;

  localparam logic [NUM_W-1:0] REG_CTL   = 5'h00;
  localparam logic [NUM_W-1:0] REG_LO    = 5'h08;
  localparam logic [NUM_W-1:0] REG_HI    = 5'h09;
  localparam logic [NUM_W-1:0] REG_ATTR  = 5'h0A;
  localparam logic [NUM_W-1:0] REG_VLD   = 5'h0B;
  localparam logic [NUM_W-1:0] REG_PC0   = 5'h10;

  localparam int ATTR_MSK_LSB = 16;
  localparam logic [DATA_W-1:0] DONE_WORD = 32'h0000_FFFF;
endpackage

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_PC = 4,
  parameter int ATTR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ext_wr_i,
  input  logic [NUM_W-1:0]               ext_num_i,
  input  logic [DATA_W-1:0]              ext_wdata_i,
  input  logic                           cpu_wr_i,
  input  logic [NUM_W-1:0]               cpu_num_i,
  input  logic [DATA_W-1:0]              cpu_wdata_i,
  input  logic [NUM_W-1:0]               rd_num_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [DATA_W-1:0]              lo_o,
  output logic [DATA_W-1:0]              hi_o,
  output logic [ATTR_W-1:0]              attr_val_o,
  output logic [ATTR_W-1:0]              attr_msk_o,
  output logic [NUM_PC-1:0]              pc_vld_o,
  output logic [NUM_PC-1:0][DATA_W-1:0]  pbr_o
);
  logic lock_q;
  logic cpu_ok;

  // processor path is gated by the host-owned lock
  assign cpu_ok = cpu_wr_i && !lock_q;

  function automatic logic ext_sel(input logic [NUM_W-1:0] n);
    return ext_wr_i && (ext_num_i == n);
  endfunction

  function automatic logic cpu_sel(input logic [NUM_W-1:0] n);
    return cpu_ok && (cpu_num_i == n);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (ext_sel(REG_CTL)) lock_q <= ext_wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o       <= '0;
      hi_o       <= '0;
      attr_val_o <= '0;
      attr_msk_o <= '0;
      pc_vld_o   <= '0;
    end else begin
      if (ext_sel(REG_LO))      lo_o <= ext_wdata_i;
      else if (cpu_sel(REG_LO)) lo_o <= cpu_wdata_i;
      if (ext_sel(REG_HI))      hi_o <= ext_wdata_i;
      else if (cpu_sel(REG_HI)) hi_o <= cpu_wdata_i;
      if (ext_sel(REG_ATTR)) begin
        attr_val_o <= ext_wdata_i[ATTR_W-1:0];
        attr_msk_o <= ext_wdata_i[ATTR_MSK_LSB +: ATTR_W];
      end else if (cpu_sel(REG_ATTR)) begin
        attr_val_o <= cpu_wdata_i[ATTR_W-1:0];
        attr_msk_o <= cpu_wdata_i[ATTR_MSK_LSB +: ATTR_W];
      end
      if (ext_sel(REG_VLD))      pc_vld_o <= ext_wdata_i[NUM_PC-1:0];
      else if (cpu_sel(REG_VLD)) pc_vld_o <= cpu_wdata_i[NUM_PC-1:0];
    end
  end

  for (genvar k = 0; k < NUM_PC; k++) begin : g_pbr
    localparam logic [NUM_W-1:0] NUM_K = REG_PC0 + NUM_W'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              pbr_o[k] <= '0;
      else if (ext_sel(NUM_K))  pbr_o[k] <= ext_wdata_i;
      else if (cpu_sel(NUM_K))  pbr_o[k] <= cpu_wdata_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_num_i)
      REG_CTL:  rd_data_o[0] = lock_q;
      REG_LO:   rd_data_o = lo_o;
      REG_HI:   rd_data_o = hi_o;
      REG_ATTR: begin
        rd_data_o[ATTR_W-1:0] = attr_val_o;
        rd_data_o[ATTR_MSK_LSB +: ATTR_W] = attr_msk_o;
      end
      REG_VLD:  rd_data_o[NUM_PC-1:0] = pc_vld_o;
      default: begin
        for (int k = 0; k < NUM_PC; k++)
          if (rd_num_i == REG_PC0 + NUM_W'(k)) rd_data_o = pbr_o[k];
      end
    endcase
  end

  // R6: a locked processor write without host write leaves the bounds alone
  p_lock_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && cpu_wr_i && !ext_wr_i) |=> ($stable(lo_o) && $stable(hi_o) && $stable(pc_vld_o)));

  // R6: processor can never change the lock
  p_lock_host_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_wr_i |=> $stable(lock_q));

  // R7: host data wins a same-register collision
  p_ext_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_wr_i && cpu_wr_i && ext_num_i == REG_LO && cpu_num_i == REG_LO)
      |=> (lo_o == $past(ext_wdata_i)));
endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp
  import dbg_bkpt_pkg::*;
#(
  parameter int ATTR_W = 8
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [ATTR_W-1:0] attr_val_i,
  input  logic [ATTR_W-1:0] attr_msk_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [ATTR_W-1:0] attr_i,
  output logic              in_range_o,
  output logic              attr_ok_o,
  output logic              hit_o
);
  assign in_range_o = (addr_i >= lo_i) && (addr_i <= hi_i);
  // mask 1 = don't care
  assign attr_ok_o  = &(~(attr_i ^ attr_val_i) | attr_msk_i);
  assign hit_o      = in_range_o && attr_ok_o;

  always_comb begin
    // R8: an address below the lower bound never reports in range
    p_below_lo_r8: assert (!(in_range_o && (addr_i < lo_i)));
  end
endmodule

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_PC = 4
) (
  input  logic [NUM_PC-1:0][DATA_W-1:0] pbr_i,
  input  logic [NUM_PC-1:0]             vld_i,
  input  logic [DATA_W-1:0]             pc_i,
  output logic [NUM_PC-1:0]             hit_o
);
  for (genvar k = 0; k < NUM_PC; k++) begin : g_cmp
    assign hit_o[k] = vld_i[k] && (pc_i == pbr_i[k]);
  end
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_PC = 4,
  parameter int ATTR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_wr_i,
  input  logic              ext_rd_i,
  input  logic [4:0]        ext_num_i,
  input  logic [31:0]       ext_wdata_i,
  output logic              resp_vld_o,
  output logic [31:0]       resp_o,
  input  logic              cpu_wr_i,
  input  logic [4:0]        cpu_num_i,
  input  logic [31:0]       cpu_wdata_i,
  input  logic [31:0]       core_addr_i,
  input  logic [ATTR_W-1:0] core_attr_i,
  input  logic [31:0]       core_pc_i,
  output logic              in_range_o,
  output logic              attr_ok_o,
  output logic              addr_hit_o,
  output logic [NUM_PC-1:0] pc_hit_o
);
  logic [DATA_W-1:0]             rd_data, lo, hi;
  logic [ATTR_W-1:0]             attr_val, attr_msk;
  logic [NUM_PC-1:0]             pc_vld;
  logic [NUM_PC-1:0][DATA_W-1:0] pbr;

  dbg_reg_file #(.NUM_PC(NUM_PC), .ATTR_W(ATTR_W)) u_regs (
    .clk_i, .rst_ni,
    .ext_wr_i, .ext_num_i, .ext_wdata_i,
    .cpu_wr_i, .cpu_num_i, .cpu_wdata_i,
    .rd_num_i(ext_num_i), .rd_data_o(rd_data),
    .lo_o(lo), .hi_o(hi), .attr_val_o(attr_val), .attr_msk_o(attr_msk),
    .pc_vld_o(pc_vld), .pbr_o(pbr)
  );

  dbg_addr_cmp #(.ATTR_W(ATTR_W)) u_addr (
    .lo_i(lo), .hi_i(hi), .attr_val_i(attr_val), .attr_msk_i(attr_msk),
    .addr_i(core_addr_i), .attr_i(core_attr_i),
    .in_range_o, .attr_ok_o, .hit_o(addr_hit_o)
  );

  dbg_pc_cmp #(.NUM_PC(NUM_PC)) u_pc (
    .pbr_i(pbr), .vld_i(pc_vld), .pc_i(core_pc_i), .hit_o(pc_hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_vld_o <= 1'b0;
      resp_o     <= '0;
    end else begin
      resp_vld_o <= ext_wr_i || ext_rd_i;
      resp_o     <= ext_wr_i ? DONE_WORD : rd_data;
    end
  end

  p_done_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_i |=> (resp_vld_o && resp_o == 32'h0000_FFFF));

  p_idle_no_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_wr_i && !ext_rd_i) |=> !resp_vld_o);

  p_undef_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rd_i && !ext_wr_i && ext_num_i inside {5'h01, 5'h07, 5'h0C, 5'h1F}) |=> (resp_o == '0));
endmodule

// File: tb/tb_dbg_bkpt_unit.sv
module tb_dbg_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_wr = 1'b0, ext_rd = 1'b0, cpu_wr = 1'b0;
  logic [4:0]  ext_num = '0, cpu_num = '0;
  logic [31:0] ext_wdata = '0, cpu_wdata = '0;
  logic [31:0] core_addr = '0, core_pc = '0;
  logic [7:0]  core_attr = '0;
  logic        resp_vld, in_range, attr_ok, addr_hit;
  logic [31:0] resp;
  logic [3:0]  pc_hit;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  dbg_bkpt_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ext_wr_i(ext_wr), .ext_rd_i(ext_rd), .ext_num_i(ext_num), .ext_wdata_i(ext_wdata),
    .resp_vld_o(resp_vld), .resp_o(resp),
    .cpu_wr_i(cpu_wr), .cpu_num_i(cpu_num), .cpu_wdata_i(cpu_wdata),
    .core_addr_i(core_addr), .core_attr_i(core_attr), .core_pc_i(core_pc),
    .in_range_o(in_range), .attr_ok_o(attr_ok), .addr_hit_o(addr_hit), .pc_hit_o(pc_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic ext_write(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk); ext_wr = 1'b1; ext_num = n; ext_wdata = d;
    @(negedge clk); ext_wr = 1'b0;
    check("R2 valid", {31'b0, resp_vld}, 32'd1);
    check("R2 word", resp, 32'h0000_FFFF);
  endtask

  task automatic ext_read(input logic [4:0] n, output logic [31:0] d);
    @(negedge clk); ext_rd = 1'b1; ext_num = n;
    @(negedge clk); ext_rd = 1'b0;
    check("R3 valid", {31'b0, resp_vld}, 32'd1);
    d = resp;
  endtask

  task automatic cpu_write(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_num = n; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic t_reset_r1;
    ext_read(5'h08, rv); check("R1 lo", rv, 0);
    ext_read(5'h00, rv); check("R1 ctl", rv, 0);
    ext_read(5'h10, rv); check("R1 pbr0", rv, 0);
    check("R1 pc_hit", {28'b0, pc_hit}, 0);
    @(negedge clk); check("R2 idle", {31'b0, resp_vld}, 0);
  endtask

  task automatic t_readback_r3_r4;
    ext_write(5'h0A, 32'hFFFF_FFFF);
    ext_read(5'h0A, rv); check("R3 attr bits", rv, 32'h00FF_00FF);
    ext_write(5'h0B, 32'hFFFF_FFFF);
    ext_read(5'h0B, rv); check("R3 vld bits", rv, 32'h0000_000F);
    ext_write(5'h13, 32'hCAFE_0013);
    ext_read(5'h13, rv); check("R3 pbr3", rv, 32'hCAFE_0013);
    ext_write(5'h14, 32'h1234_5678);
    ext_read(5'h14, rv); check("R4 undefined 0x14", rv, 0);
    ext_read(5'h01, rv); check("R4 undefined 0x01", rv, 0);
    ext_read(5'h1F, rv); check("R4 undefined 0x1F", rv, 0);
  endtask

  task automatic t_cpu_r5;
    cpu_write(5'h08, 32'h0000_1000);
    ext_read(5'h08, rv); check("R5 cpu lo", rv, 32'h0000_1000);
    cpu_write(5'h11, 32'h0000_AAAA);
    ext_read(5'h11, rv); check("R5 cpu pbr1", rv, 32'h0000_AAAA);
  endtask

  task automatic t_lock_r6;
    ext_write(5'h00, 32'h1);
    ext_read(5'h00, rv); check("R6 lock set", rv, 32'h1);
    cpu_write(5'h08, 32'hDEAD_0000);
    ext_read(5'h08, rv); check("R6 locked lo", rv, 32'h0000_1000);
    cpu_write(5'h11, 32'h0);
    ext_read(5'h11, rv); check("R6 locked pbr1", rv, 32'h0000_AAAA);
    cpu_write(5'h00, 32'h0);
    ext_read(5'h00, rv); check("R6 cpu cannot unlock", rv, 32'h1);
    ext_write(5'h00, 32'h0);
    cpu_write(5'h08, 32'h0000_1000);
  endtask

  task automatic t_collide_r7;
    @(negedge clk);
    ext_wr = 1'b1; ext_num = 5'h09; ext_wdata = 32'h0000_1FFF;
    cpu_wr = 1'b1; cpu_num = 5'h09; cpu_wdata = 32'h7777_7777;
    @(negedge clk); ext_wr = 1'b0; cpu_wr = 1'b0;
    ext_read(5'h09, rv); check("R7 host wins", rv, 32'h0000_1FFF);
  endtask

  task automatic t_range_r8;
    core_attr = 8'h00;
    ext_write(5'h0A, 32'h00FF_0000);
    core_addr = 32'h0000_0FFF; #1 check("R8 below", {31'b0, in_range}, 0);
    core_addr = 32'h0000_1000; #1 check("R8 at lo", {31'b0, in_range}, 1);
    core_addr = 32'h0000_1FFF; #1 check("R8 at hi", {31'b0, in_range}, 1);
    core_addr = 32'h0000_2000; #1 check("R8 above", {31'b0, in_range}, 0);
  endtask

  task automatic t_attr_r9;
    ext_write(5'h0A, 32'h000F_005A);
    core_addr = 32'h0000_1800;
    core_attr = 8'h53; #1 check("R9 masked match", {31'b0, attr_ok}, 1);
    check("R9 hit", {31'b0, addr_hit}, 1);
    core_attr = 8'h6A; #1 check("R9 mismatch", {31'b0, attr_ok}, 0);
    check("R9 no hit", {31'b0, addr_hit}, 0);
    core_attr = 8'h5A; core_addr = 32'h0000_2000;
    #1 check("R9 attr only", {30'b0, attr_ok, addr_hit}, 32'd2);
  endtask

  task automatic t_pc_r10;
    ext_write(5'h10, 32'h0000_4000);
    ext_write(5'h12, 32'h0000_4400);
    ext_write(5'h0B, 32'h1);
    @(negedge clk);
    core_pc = 32'h0000_4400; #1 check("R10 invalid slot", {28'b0, pc_hit}, 0);
    core_pc = 32'h0000_4000; #1 check("R10 slot0", {28'b0, pc_hit}, 32'h1);
    ext_write(5'h0B, 32'h5);
    core_pc = 32'h0000_4400; #1 check("R10 slot2", {28'b0, pc_hit}, 32'h4);
    core_pc = 32'h0000_4404; #1 check("R10 near miss", {28'b0, pc_hit}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_readback_r3_r4();
    t_cpu_r5();
    t_lock_r6();
    t_collide_r7();
    t_range_r8();
    t_attr_r9();
    t_pc_r10();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule